// File: doc/BRIEF.md
# Hardwired Accumulator Control Unit

This block is the control sequencer for a small accumulator machine. Each instruction is one 16-bit word. The machine fetches it from byte-addressed memory and then runs it against one memory operand. The block keeps a two-bit instruction-cycle code and a three-step phase counter. From these and the instruction's 2-bit opcode it drives every register-transfer enable, the program-counter step, the ALU operation selects and the memory strobes. Each output is a fixed sum-of-products term, so no microcode store is involved.

A fetch takes three phases: program counter to address register, memory read into the buffer register with the program counter advanced by two, then buffer register into the instruction register. An execute then follows. LOAD, ADD and MUL take three phases each. STORE takes only two, because it writes the accumulator out instead of reading an operand. The opcode field of the instruction register connects to the block directly. The block looks at the opcode only while the cycle code says execute.

Top module: `acc_ctl_unit`

## Requirements
- R1: A synchronous active-high reset puts the block in fetch phase 1. It stays there while reset is held. In that phase the only active output is `mar_ld_pc`.
- R2: In fetch phase 2, for any opcode, `bus_en`, `mem_rd`, `mbr_ld_mem` and `pc_inc2` are active and all other outputs are inactive.
- R3: In fetch phase 3 only `ir_ld_mbr` is active. During all three fetch phases the opcode input has no effect on any output.
- R4: Execute phase 1 asserts `mar_ld_ir` for every opcode. For STORE (opcode 01), `mbr_ld_ac` is also active.
- R5: In execute phase 2 for LOAD (00), ADD (10) and MUL (11), the active outputs are exactly `bus_en`, `mem_rd` and `mbr_ld_mem`.
- R6: In execute phase 2 for STORE, the active outputs are exactly `bus_en` and `mem_wr`. The next cycle is fetch phase 1, so a STORE instruction takes five cycles.
- R7: In execute phase 3 for LOAD, only `ac_ld_mbr` is active.
- R8: In execute phase 3 for ADD, the active outputs are `alu_a_oe`, `alu_b_oe`, `ac_ld_alu` and `alu_add`. For MUL, the same set is active with `alu_mul` in place of `alu_add`.
- R9: After execute phase 3 the next cycle is fetch phase 1, so LOAD, ADD and MUL take six cycles. `mem_rd` and `mem_wr` are never active together, and `mar_ld_pc` and `mar_ld_ir` are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OP_W (2) | Opcode field of the instruction register |
| bus_en | output | 1 | Memory bus cycle enable |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mar_ld_pc | output | 1 | Load address register from program counter |
| mar_ld_ir | output | 1 | Load address register from instruction address field |
| mbr_ld_mem | output | 1 | Load buffer register from memory data |
| mbr_ld_ac | output | 1 | Load buffer register from accumulator |
| ir_ld_mbr | output | 1 | Load instruction register from buffer register |
| ac_ld_mbr | output | 1 | Load accumulator from buffer register |
| pc_inc2 | output | 1 | Advance program counter by two |
| alu_a_oe | output | 1 | Drive accumulator onto ALU input A |
| alu_b_oe | output | 1 | Drive buffer register onto ALU input B |
| ac_ld_alu | output | 1 | Load accumulator from ALU result |
| alu_add | output | 1 | ALU add select |
| alu_mul | output | 1 | ALU multiply select |

## Verification
The instructions run back to back in the order LOAD, STORE, ADD, MUL. This order makes the five-cycle STORE change the alignment of the instructions that follow it, so a wrong phase count would show up as a mismatch later in the run. The opcode input holds the pending instruction's value through its fetch, which exposes any opcode leaking into the fetch phases. The last execute phase is checked for all three reading opcodes, which tells a decode error apart from a select error. A reset applied in the middle of an ADD checks that the block restarts cleanly from any phase.

// File: rtl/accctl_pkg.sv
package accctl_pkg;

    localparam int OP_W_DEF = 2;

    // opcode line indices (fixed by the instruction encoding)
    localparam int OP_LOAD  = 0;
    localparam int OP_STORE = 1;
    localparam int OP_ADD   = 2;
    localparam int OP_MUL   = 3;

    // instruction-cycle code; 2'b01 and 2'b11 are not used
    typedef enum logic [1:0] {
        CYC_FETCH = 2'b00,
        CYC_EXEC  = 2'b10
    } cyc_e;

    typedef enum logic [1:0] {
        PH_T1 = 2'd0,
        PH_T2 = 2'd1,
        PH_T3 = 2'd2
    } phase_e;

    typedef struct packed {
        logic bus_en;
        logic mem_rd;
        logic mem_wr;
        logic mar_ld_pc;
        logic mar_ld_ir;
        logic mbr_ld_mem;
        logic mbr_ld_ac;
        logic ir_ld_mbr;
        logic ac_ld_mbr;
        logic pc_inc2;
        logic alu_a_oe;
        logic alu_b_oe;
        logic ac_ld_alu;
        logic alu_add;
        logic alu_mul;
    } ctl_word_t;

    function automatic phase_e phase_step(input phase_e ph);
        case (ph)
            PH_T1:   return PH_T2;
            PH_T2:   return PH_T3;
            default: return PH_T1;
        endcase
    endfunction

endpackage

// File: rtl/accctl_sequencer.sv
module accctl_sequencer
    import accctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic store_line,
    output logic in_fetch,
    output logic in_exec,
    output logic ph_t1,
    output logic ph_t2,
    output logic ph_t3
);

    cyc_e   cyc_q, cyc_d;
    phase_e ph_q, ph_d;

    always_comb begin
        cyc_d = cyc_q;
        ph_d  = phase_step(ph_q);
        case (cyc_q)
            CYC_FETCH: begin
                if (ph_q == PH_T3) begin
                    cyc_d = CYC_EXEC;
                    ph_d  = PH_T1;
                end
            end
            CYC_EXEC: begin
                if (ph_q == PH_T3 || (ph_q == PH_T2 && store_line)) begin
                    cyc_d = CYC_FETCH;
                    ph_d  = PH_T1;
                end
            end
            default: begin
                cyc_d = CYC_FETCH;
                ph_d  = PH_T1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= CYC_FETCH;
            ph_q  <= PH_T1;
        end else begin
            cyc_q <= cyc_d;
            ph_q  <= ph_d;
        end
    end

    assign in_fetch = (cyc_q == CYC_FETCH);
    assign in_exec  = (cyc_q == CYC_EXEC);
    assign ph_t1    = (ph_q == PH_T1);
    assign ph_t2    = (ph_q == PH_T2);
    assign ph_t3    = (ph_q == PH_T3);

    a_r3_fetch_enters_exec: assert property (@(posedge clk) disable iff (rst)
        (in_fetch && ph_t3) |=> (in_exec && ph_t1));

    a_r9_exec_t3_back_to_fetch: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ph_t3) |=> (in_fetch && ph_t1));

    a_r6_store_ends_at_t2: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ph_t2 && store_line) |=> (in_fetch && ph_t1));

    a_r9_one_phase: assert property (@(posedge clk) disable iff (rst)
        $onehot({ph_t1, ph_t2, ph_t3}));

endmodule

// File: rtl/accctl_opdecode.sv
module accctl_opdecode #(
    parameter  int OP_W    = 2,
    localparam int NUM_OPS = 1 << OP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [OP_W-1:0]    opcode,
    input  logic               enable,
    output logic [NUM_OPS-1:0] op_lines
);

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_line
        assign op_lines[k] = enable && (opcode == OP_W'(k));
    end

    a_r4_lines_onehot: assert property (@(posedge clk) disable iff (rst)
        enable |-> $onehot(op_lines));

endmodule

// File: rtl/accctl_equations.sv
module accctl_equations
    import accctl_pkg::*;
#(
    parameter int NUM_OPS = 4
) (
    input  logic               in_fetch,
    input  logic               in_exec,
    input  logic               ph_t1,
    input  logic               ph_t2,
    input  logic               ph_t3,
    input  logic [NUM_OPS-1:0] op_lines,
    output ctl_word_t          ctl
);

    logic i0, i1, i2, i3, any_op, rd_op, alu_op;

    assign i0     = op_lines[OP_LOAD];
    assign i1     = op_lines[OP_STORE];
    assign i2     = op_lines[OP_ADD];
    assign i3     = op_lines[OP_MUL];
    assign any_op = i0 | i1 | i2 | i3;
    assign rd_op  = i0 | i2 | i3;
    assign alu_op = i2 | i3;

    always_comb begin
        ctl            = '0;
        ctl.mar_ld_pc  = in_fetch & ph_t1;
        ctl.pc_inc2    = in_fetch & ph_t2;
        ctl.ir_ld_mbr  = in_fetch & ph_t3;
        ctl.bus_en     = (in_fetch & ph_t2) | (in_exec & any_op & ph_t2);
        ctl.mbr_ld_mem = (in_fetch & ph_t2) | (in_exec & rd_op & ph_t2);
        ctl.mem_rd     = (in_fetch & ph_t2) | (in_exec & rd_op & ph_t2);
        ctl.mar_ld_ir  = in_exec & any_op & ph_t1;
        ctl.mbr_ld_ac  = in_exec & i1 & ph_t1;
        ctl.mem_wr     = in_exec & i1 & ph_t2;
        ctl.ac_ld_mbr  = in_exec & i0 & ph_t3;
        ctl.alu_a_oe   = in_exec & alu_op & ph_t3;
        ctl.alu_b_oe   = in_exec & alu_op & ph_t3;
        ctl.ac_ld_alu  = in_exec & alu_op & ph_t3;
        ctl.alu_add    = in_exec & i2 & ph_t3;
        ctl.alu_mul    = in_exec & i3 & ph_t3;
    end

endmodule

// File: rtl/acc_ctl_unit.sv
module acc_ctl_unit
    import accctl_pkg::*;
#(
    parameter int OP_W = OP_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output logic            bus_en,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            mar_ld_pc,
    output logic            mar_ld_ir,
    output logic            mbr_ld_mem,
    output logic            mbr_ld_ac,
    output logic            ir_ld_mbr,
    output logic            ac_ld_mbr,
    output logic            pc_inc2,
    output logic            alu_a_oe,
    output logic            alu_b_oe,
    output logic            ac_ld_alu,
    output logic            alu_add,
    output logic            alu_mul
);

    localparam int NUM_OPS = 1 << OP_W;

    logic               in_fetch, in_exec, ph_t1, ph_t2, ph_t3;
    logic [NUM_OPS-1:0] op_lines;
    ctl_word_t          ctl;

    accctl_opdecode #(.OP_W(OP_W)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .opcode   (opcode),
        .enable   (in_exec),
        .op_lines (op_lines)
    );

    accctl_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .store_line (op_lines[OP_STORE]),
        .in_fetch   (in_fetch),
        .in_exec    (in_exec),
        .ph_t1      (ph_t1),
        .ph_t2      (ph_t2),
        .ph_t3      (ph_t3)
    );

    accctl_equations #(.NUM_OPS(NUM_OPS)) u_eq (
        .in_fetch (in_fetch),
        .in_exec  (in_exec),
        .ph_t1    (ph_t1),
        .ph_t2    (ph_t2),
        .ph_t3    (ph_t3),
        .op_lines (op_lines),
        .ctl      (ctl)
    );

    assign bus_en     = ctl.bus_en;
    assign mem_rd     = ctl.mem_rd;
    assign mem_wr     = ctl.mem_wr;
    assign mar_ld_pc  = ctl.mar_ld_pc;
    assign mar_ld_ir  = ctl.mar_ld_ir;
    assign mbr_ld_mem = ctl.mbr_ld_mem;
    assign mbr_ld_ac  = ctl.mbr_ld_ac;
    assign ir_ld_mbr  = ctl.ir_ld_mbr;
    assign ac_ld_mbr  = ctl.ac_ld_mbr;
    assign pc_inc2    = ctl.pc_inc2;
    assign alu_a_oe   = ctl.alu_a_oe;
    assign alu_b_oe   = ctl.alu_b_oe;
    assign ac_ld_alu  = ctl.ac_ld_alu;
    assign alu_add    = ctl.alu_add;
    assign alu_mul    = ctl.alu_mul;

    a_r9_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    a_r9_mar_single_source: assert property (@(posedge clk) disable iff (rst)
        !(mar_ld_pc && mar_ld_ir));

    a_r3_fetch_ignores_opcode: assert property (@(posedge clk) disable iff (rst)
        in_fetch |-> !(mem_wr || mbr_ld_ac || ac_ld_mbr || alu_add || alu_mul || mar_ld_ir));

    a_r8_alu_select_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({alu_add, alu_mul, ac_ld_mbr}));

endmodule

// File: tb/test_acc_ctl_unit.sv
`timescale 1ns/1ps
module test_acc_ctl_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] opcode = 2'b00;
    logic bus_en, mem_rd, mem_wr, mar_ld_pc, mar_ld_ir, mbr_ld_mem, mbr_ld_ac;
    logic ir_ld_mbr, ac_ld_mbr, pc_inc2, alu_a_oe, alu_b_oe, ac_ld_alu, alu_add, alu_mul;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    acc_ctl_unit i_acc_ctl_unit (
        .clk(clk), .rst(rst), .opcode(opcode),
        .bus_en(bus_en), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mar_ld_pc(mar_ld_pc), .mar_ld_ir(mar_ld_ir),
        .mbr_ld_mem(mbr_ld_mem), .mbr_ld_ac(mbr_ld_ac),
        .ir_ld_mbr(ir_ld_mbr), .ac_ld_mbr(ac_ld_mbr), .pc_inc2(pc_inc2),
        .alu_a_oe(alu_a_oe), .alu_b_oe(alu_b_oe), .ac_ld_alu(ac_ld_alu),
        .alu_add(alu_add), .alu_mul(alu_mul)
    );

    // bit positions of the observed control word
    localparam logic [14:0] B_BUS = 15'h4000, B_RD  = 15'h2000, B_WR  = 15'h1000;
    localparam logic [14:0] B_MPC = 15'h0800, B_MIR = 15'h0400, B_BMM = 15'h0200;
    localparam logic [14:0] B_BAC = 15'h0100, B_IRB = 15'h0080, B_ACB = 15'h0040;
    localparam logic [14:0] B_INC = 15'h0020, B_AOE = 15'h0010, B_BOE = 15'h0008;
    localparam logic [14:0] B_ACA = 15'h0004, B_ADD = 15'h0002, B_MUL = 15'h0001;

    localparam logic [14:0] W_F1  = B_MPC;
    localparam logic [14:0] W_F2  = B_BUS | B_RD | B_BMM | B_INC;
    localparam logic [14:0] W_F3  = B_IRB;
    localparam logic [14:0] W_E1  = B_MIR;
    localparam logic [14:0] W_E1S = B_MIR | B_BAC;
    localparam logic [14:0] W_E2R = B_BUS | B_RD | B_BMM;
    localparam logic [14:0] W_E2S = B_BUS | B_WR;
    localparam logic [14:0] W_E3L = B_ACB;
    localparam logic [14:0] W_E3A = B_AOE | B_BOE | B_ACA | B_ADD;
    localparam logic [14:0] W_E3M = B_AOE | B_BOE | B_ACA | B_MUL;

    // {requirement number, opcode, expected word}; one row per clock
    localparam int NROWS = 23;
    localparam logic [20:0] VEC [NROWS] = '{
        {4'd1, 2'b00, W_F1},  // R1 first cycle after reset
        {4'd2, 2'b00, W_F2},  // R2
        {4'd3, 2'b00, W_F3},  // R3
        {4'd4, 2'b00, W_E1},  // R4 LOAD
        {4'd5, 2'b00, W_E2R}, // R5 LOAD
        {4'd7, 2'b00, W_E3L}, // R7
        {4'd9, 2'b01, W_F1},  // R9 back in fetch after six cycles; R3 STORE code ignored
        {4'd2, 2'b01, W_F2},  // R2 STORE code ignored
        {4'd3, 2'b01, W_F3},  // R3
        {4'd4, 2'b01, W_E1S}, // R4 STORE
        {4'd6, 2'b01, W_E2S}, // R6
        {4'd6, 2'b10, W_F1},  // R6 five-cycle STORE
        {4'd2, 2'b10, W_F2},  // R2
        {4'd3, 2'b10, W_F3},  // R3
        {4'd4, 2'b10, W_E1},  // R4 ADD
        {4'd5, 2'b10, W_E2R}, // R5 ADD
        {4'd8, 2'b10, W_E3A}, // R8 ADD
        {4'd9, 2'b11, W_F1},  // R9
        {4'd3, 2'b11, W_F2},  // R3 MUL code ignored in fetch
        {4'd3, 2'b11, W_F3},  // R3
        {4'd4, 2'b11, W_E1},  // R4 MUL
        {4'd5, 2'b11, W_E2R}, // R5 MUL
        {4'd8, 2'b11, W_E3M}  // R8 MUL
    };

    function automatic logic [14:0] observed();
        return {bus_en, mem_rd, mem_wr, mar_ld_pc, mar_ld_ir, mbr_ld_mem, mbr_ld_ac,
                ir_ld_mbr, ac_ld_mbr, pc_inc2, alu_a_oe, alu_b_oe, ac_ld_alu,
                alu_add, alu_mul};
    endfunction

    task automatic check_word(input int req, input logic [14:0] exp);
        logic [14:0] got;
        got = observed();
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d got %b expected %b", req, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_word(1, W_F1);          // R1 held in reset
        rst = 1'b0;

        // table walk: instructions back to back
        for (int i = 0; i < NROWS; i++) begin
            if (i > 0) @(negedge clk);
            opcode = VEC[i][16:15];
            #0.5;
            check_word(int'(VEC[i][20:17]), VEC[i][14:0]);
        end

        // R9: after MUL execute t3 the next cycle is fetch t1
        @(negedge clk);
        opcode = 2'b10;
        #0.5;
        check_word(9, W_F1);

        // R1: reset in the middle of an ADD execute
        repeat (3) @(negedge clk);   // F2, F3, E1
        @(negedge clk);              // E2
        #0.5;
        check_word(5, W_E2R);        // R5 before reset
        rst = 1'b1;
        @(negedge clk);
        #0.5;
        check_word(1, W_F1);         // R1 reset restarts fetch
        rst = 1'b0;
        @(negedge clk);
        #0.5;
        check_word(1, W_F2);         // R1 normal sequence resumes

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule